// File: doc/BRIEF.md
# Interrupt Status and Alarm Match Unit

This block gathers three interrupt sources of a timekeeping core: a periodic tick, an update-ended tick and a time-of-day alarm. It holds the control byte that enables each source, and it holds a read-to-clear status byte with one flag per source. It also drives an active-low open-drain interrupt request, which is modelled here as a drive-enable output. A flag is set whenever its event fires, whether or not its enable is on. The interrupt request is active while at least one source has both its flag and its enable set.

A status read is a level on `stat_rd`. On the first clock with `stat_rd` high, a two-state machine takes a snapshot of the status byte and moves from `RD_IDLE` to `RD_HELD` (transition *read start*). While it stays in `RD_HELD`, the status output holds that snapshot, and any new events are collected in a pending set. On the first clock with `stat_rd` low, it returns to `RD_IDLE` (transition *read end*). At that edge all flags are cleared, and the pending events, plus any event in that same cycle, are posted as the new flags, so no event is lost. Without a read, `RD_IDLE` stays in `RD_IDLE` (transition *idle hold*). While the read goes on, `RD_HELD` stays in `RD_HELD` (transition *read hold*).

The alarm comparator checks the hour, minute and second alarm bytes against the current time bytes each time an update pulse arrives. An alarm byte whose two top bits are both 1 acts as a wildcard and matches any value.

Top module: `irq_status_unit`

## Requirements
- R1: The status byte has IRQF in bit 7, the periodic flag PF in bit 6, the alarm flag AF in bit 5 and the update flag UF in bit 4. Bits 3..0 always read 0.
- R2: IRQF = (PF and PIE) or (AF and AIE) or (UF and UIE). `irq_oe` is 1 exactly when the live IRQF is 1.
- R3: A one-cycle pulse on `per_evt`, `upd_evt` or a match at `alarm_evt` sets PF, UF or AF respectively on the next clock edge, whatever the enable bits are.
- R4: Writing an enable bit to 1 while its flag is already set raises `irq_oe` in the cycle after the write.
- R5: During a status read, `stat_rdata` holds the value it had in the first cycle of `stat_rd` high, for as long as `stat_rd` stays high. At the edge where `stat_rd` is first seen low, PF, AF, UF and IRQF are cleared.
- R6: An event that arrives during a read, or in the cycle in which the read ends, sets its flag at the edge that ends the read.
- R7: `alarm_evt` = `upd_evt` and, for each of hour, minute and second, (alarm byte equals time byte, or alarm byte bits 7..6 are 11). An alarm match on an update sets AF.
- R8: While `rst_n` is low at a clock edge, the control byte and PF, AF, UF and IRQF are cleared, the read state returns to idle and `irq_oe` goes to 0.
- R9: A control write with bit 7 (SET) = 1 stores UIE (bit 4) as 0, whatever value is written to bit 4.
- R10: The control byte reads back on `ctrl_rdata` the cycle after a write. Bit 6 is PIE, bit 5 AIE, bit 4 UIE, bit 3 SQWE, and bit 7 is SET.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control byte write strobe, one cycle |
| ctrl_wdata | input | 8 | Control byte write data |
| ctrl_rdata | output | 8 | Control byte contents |
| stat_rd | input | 1 | Status read in progress (level) |
| stat_rdata | output | 8 | Status byte: snapshot while a read is held, live otherwise |
| per_evt | input | 1 | Periodic tick pulse |
| upd_evt | input | 1 | Update-ended pulse; also triggers the alarm compare |
| cur_hr | input | 8 | Current hour byte |
| cur_min | input | 8 | Current minute byte |
| cur_sec | input | 8 | Current second byte |
| alm_hr | input | 8 | Hour alarm byte |
| alm_min | input | 8 | Minute alarm byte |
| alm_sec | input | 8 | Second alarm byte |
| irq_oe | output | 1 | Drive-enable of the active-low interrupt pin |
| alarm_evt | output | 1 | Alarm match on this update |

## Verification
Two functions can fall in the same cycle. The first is flag posting: an event pulse sets its flag. The second is the read-to-clear action: the end of a status read wipes every flag. The bench provokes the collision directly. It pulses `per_evt` and `upd_evt` (with a matching alarm) in the very cycle where `stat_rd` drops, and also in the cycle where `stat_rd` first rises. It then repeats such overlaps many times in a long pseudo-random phase. The behavioural reference expects each such event to show up as a set flag right after the read ends, never to vanish. It also expects the snapshot to stay frozen on `stat_rdata` for the whole read.

// File: rtl/irqu_pkg.sv
package irqu_pkg;
    localparam int BYTE_W = 8;
    localparam int N_SRC  = 3;

    // source vector bit positions, ordered as in the status byte
    localparam int S_PER = 2;
    localparam int S_ALM = 1;
    localparam int S_UPD = 0;

    // control byte bit positions
    localparam int C_SET  = 7;
    localparam int C_PIE  = 6;
    localparam int C_AIE  = 5;
    localparam int C_UIE  = 4;
    localparam int C_SQWE = 3;

    typedef logic [N_SRC-1:0] src_vec_t;

    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_HELD = 1'b1
    } rd_state_t;
endpackage

// File: rtl/irqu_alarm_cmp.sv
module irqu_alarm_cmp #(
    parameter int FIELD_W  = 8,
    parameter int N_FIELDS = 3
) (
    input  logic [N_FIELDS*FIELD_W-1:0] cur_flat,
    input  logic [N_FIELDS*FIELD_W-1:0] alm_flat,
    output logic                        match
);
    localparam int WILD_HI = FIELD_W - 1;

    logic [N_FIELDS-1:0] hit;

    generate
        for (genvar g = 0; g < N_FIELDS; g++) begin : g_fld
            logic [FIELD_W-1:0] cur_b;
            logic [FIELD_W-1:0] alm_b;
            logic               wild;
            assign cur_b  = cur_flat[g*FIELD_W +: FIELD_W];
            assign alm_b  = alm_flat[g*FIELD_W +: FIELD_W];
            assign wild   = alm_b[WILD_HI] & alm_b[WILD_HI-1];
            assign hit[g] = wild | (alm_b == cur_b);
        end
    endgenerate

    assign match = &hit;
endmodule

// File: rtl/irqu_ctrl_reg.sv
module irqu_ctrl_reg
    import irqu_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ctrl_q,
    output src_vec_t     enables
);
    logic [W-1:0] ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (we) begin
            ctrl_d = wdata;
            if (wdata[C_SET]) begin
                ctrl_d[C_UIE] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    always_comb begin
        enables        = '0;
        enables[S_PER] = ctrl_q[C_PIE];
        enables[S_ALM] = ctrl_q[C_AIE];
        enables[S_UPD] = ctrl_q[C_UIE];
    end
endmodule

// File: rtl/irqu_flag_fsm.sv
module irqu_flag_fsm
    import irqu_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd,
    input  src_vec_t     ev,
    input  src_vec_t     en,
    output logic [W-1:0] stat_byte,
    output logic         irq_req,
    output logic         held,
    output src_vec_t     flags,
    output src_vec_t     pend
);
    localparam int PAD_W = W - 1 - N_SRC;

    rd_state_t    state_q, state_d;
    src_vec_t     flags_q, flags_d;
    src_vec_t     pend_q,  pend_d;
    logic [W-1:0] snap_q,  snap_d;
    logic         irqf_live;
    logic [W-1:0] live_byte;

    assign irqf_live = |(flags_q & en);
    assign live_byte = {irqf_live, flags_q, {PAD_W{1'b0}}};

    // next-state and data path
    always_comb begin
        state_d = state_q;
        flags_d = flags_q;
        pend_d  = pend_q;
        snap_d  = snap_q;
        unique case (state_q)
            RD_IDLE: begin
                if (rd) begin
                    state_d = RD_HELD;
                    snap_d  = live_byte;
                    pend_d  = ev;
                end else begin
                    flags_d = flags_q | ev;
                end
            end
            RD_HELD: begin
                if (rd) begin
                    pend_d = pend_q | ev;
                end else begin
                    state_d = RD_IDLE;
                    flags_d = pend_q | ev;
                    pend_d  = '0;
                end
            end
            default: begin
                state_d = RD_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            pend_q  <= '0;
            snap_q  <= '0;
        end else begin
            flags_q <= flags_d;
            pend_q  <= pend_d;
            snap_q  <= snap_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            RD_HELD: stat_byte = snap_q;
            default: stat_byte = live_byte;
        endcase
        irq_req = irqf_live;
        held    = (state_q == RD_HELD);
        flags   = flags_q;
        pend    = pend_q;
    end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irqu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_we,
    input  logic [7:0]  ctrl_wdata,
    output logic [7:0]  ctrl_rdata,
    input  logic        stat_rd,
    output logic [7:0]  stat_rdata,
    input  logic        per_evt,
    input  logic        upd_evt,
    input  logic [7:0]  cur_hr,
    input  logic [7:0]  cur_min,
    input  logic [7:0]  cur_sec,
    input  logic [7:0]  alm_hr,
    input  logic [7:0]  alm_min,
    input  logic [7:0]  alm_sec,
    output logic        irq_oe,
    output logic        alarm_evt
);
    localparam int N_FIELDS = 3;

    logic     match;
    src_vec_t enables;
    src_vec_t events;
    logic     held;
    src_vec_t flags;
    src_vec_t pend;

    irqu_alarm_cmp #(
        .FIELD_W  (BYTE_W),
        .N_FIELDS (N_FIELDS)
    ) u_cmp (
        .cur_flat ({cur_hr, cur_min, cur_sec}),
        .alm_flat ({alm_hr, alm_min, alm_sec}),
        .match    (match)
    );

    irqu_ctrl_reg #(.W(BYTE_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctrl_we),
        .wdata   (ctrl_wdata),
        .ctrl_q  (ctrl_rdata),
        .enables (enables)
    );

    assign alarm_evt = upd_evt & match;

    always_comb begin
        events        = '0;
        events[S_PER] = per_evt;
        events[S_ALM] = alarm_evt;
        events[S_UPD] = upd_evt;
    end

    irqu_flag_fsm #(.W(BYTE_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (stat_rd),
        .ev        (events),
        .en        (enables),
        .stat_byte (stat_rdata),
        .irq_req   (irq_oe),
        .held      (held),
        .flags     (flags),
        .pend      (pend)
    );
endmodule

// File: rtl/irqu_chk.sv
module irqu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_we,
    input logic [7:0] ctrl_wdata,
    input logic [7:0] ctrl_rdata,
    input logic       stat_rd,
    input logic [7:0] stat_rdata,
    input logic       per_evt,
    input logic       upd_evt,
    input logic [7:0] alm_hr,
    input logic [7:0] alm_min,
    input logic [7:0] alm_sec,
    input logic       irq_oe,
    input logic       alarm_evt,
    input logic       held,
    input logic [2:0] flags,
    input logic [2:0] pend
);
    // R1
    stat_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rdata[3:0] == 4'b0000);

    // R3
    per_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (per_evt && !stat_rd && !held) |=> flags[2]);

    // R5
    snap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && stat_rd) |=> $stable(stat_rdata));

    // R6
    post_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !stat_rd && (pend[2] || per_evt)) |=> flags[2]);

    // R9
    set_clears_uie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_wdata[7]) |=> !ctrl_rdata[4]);

    // R7
    wild_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_evt && alm_hr[7:6] == 2'b11 && alm_min[7:6] == 2'b11 && alm_sec[7:6] == 2'b11)
        |-> alarm_evt);

    // R7
    no_upd_no_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_evt |-> !alarm_evt);

    // R8
    reset_release_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq_oe && flags == 3'b000));
endmodule

bind irq_status_unit irqu_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .ctrl_rdata (ctrl_rdata),
    .stat_rd    (stat_rd),
    .stat_rdata (stat_rdata),
    .per_evt    (per_evt),
    .upd_evt    (upd_evt),
    .alm_hr     (alm_hr),
    .alm_min    (alm_min),
    .alm_sec    (alm_sec),
    .irq_oe     (irq_oe),
    .alarm_evt  (alarm_evt),
    .held       (held),
    .flags      (flags),
    .pend       (pend)
);

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic [7:0] ctrl_rdata;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_rdata;
    logic       per_evt = 1'b0;
    logic       upd_evt = 1'b0;
    logic [7:0] cur_hr = 8'h00, cur_min = 8'h00, cur_sec = 8'h00;
    logic [7:0] alm_hr = 8'h01, alm_min = 8'h01, alm_sec = 8'h01;
    logic       irq_oe;
    logic       alarm_evt;

    always #4 clk = ~clk;

    irq_status_unit u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
        .per_evt(per_evt), .upd_evt(upd_evt), .cur_hr(cur_hr), .cur_min(cur_min),
        .cur_sec(cur_sec), .alm_hr(alm_hr), .alm_min(alm_min), .alm_sec(alm_sec),
        .irq_oe(irq_oe), .alarm_evt(alarm_evt)
    );

    // staged stimulus
    logic       s_rst_n = 1'b0, s_we = 1'b0, s_rd = 1'b0, s_per = 1'b0, s_upd = 1'b0;
    logic [7:0] s_wdata = 8'h00;
    logic [7:0] s_ch = 8'h00, s_cm = 8'h00, s_cs = 8'h00;
    logic [7:0] s_ah = 8'h01, s_am = 8'h01, s_as = 8'h01;

    // behavioural reference state
    bit         m_pf, m_af, m_uf, p_pf, p_af, p_uf, m_held;
    bit [7:0]   m_snap, m_ctrl;
    int         checks = 0;
    int         failures = 0;
    string      cur_req = "R8";
    bit         done = 1'b0;

    function automatic bit fld_ok(input logic [7:0] a, input logic [7:0] c);
        return (a[7] && a[6]) || (a == c);
    endfunction

    task automatic check8(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        bit irqf, match, ev_a;
        bit [7:0] live, nctrl;
        @(negedge clk);
        rst_n = s_rst_n; ctrl_we = s_we; ctrl_wdata = s_wdata; stat_rd = s_rd;
        per_evt = s_per; upd_evt = s_upd;
        cur_hr = s_ch; cur_min = s_cm; cur_sec = s_cs;
        alm_hr = s_ah; alm_min = s_am; alm_sec = s_as;
        s_we = 1'b0; s_per = 1'b0; s_upd = 1'b0;
        #1;
        irqf  = (m_pf && m_ctrl[6]) || (m_af && m_ctrl[5]) || (m_uf && m_ctrl[4]);
        live  = {irqf, m_pf, m_af, m_uf, 4'b0000};
        match = fld_ok(alm_hr, cur_hr) && fld_ok(alm_min, cur_min) && fld_ok(alm_sec, cur_sec);
        ev_a  = upd_evt && match;
        check8("stat_rdata", stat_rdata, m_held ? m_snap : live);
        check8("irq_oe", {7'd0, irq_oe}, {7'd0, irqf});
        check8("alarm_evt", {7'd0, alarm_evt}, {7'd0, ev_a});
        check8("ctrl_rdata", ctrl_rdata, m_ctrl);
        // advance the reference to the state after the coming rising edge
        if (!rst_n) begin
            m_pf = 0; m_af = 0; m_uf = 0; p_pf = 0; p_af = 0; p_uf = 0;
            m_held = 0; m_snap = 8'h00; m_ctrl = 8'h00;
        end else begin
            if (!m_held) begin
                if (stat_rd) begin
                    m_held = 1; m_snap = live;
                    p_pf = per_evt; p_af = ev_a; p_uf = upd_evt;
                end else begin
                    m_pf |= per_evt; m_af |= ev_a; m_uf |= upd_evt;
                end
            end else if (stat_rd) begin
                p_pf |= per_evt; p_af |= ev_a; p_uf |= upd_evt;
            end else begin
                m_held = 0;
                m_pf = p_pf | per_evt; m_af = p_af | ev_a; m_uf = p_uf | upd_evt;
                p_pf = 0; p_af = 0; p_uf = 0;
            end
            if (ctrl_we) begin
                nctrl = ctrl_wdata;
                if (nctrl[7]) nctrl[4] = 1'b0;
                m_ctrl = nctrl;
            end
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        s_we = 1'b1; s_wdata = v; tick();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        logic [31:0] seed;
        logic [31:0] r;
        repeat (2) @(posedge clk);
        cur_req = "R8"; idle(3);
        s_rst_n = 1'b1; idle(1);

        cur_req = "R10"; wr_ctrl(8'h78); idle(1);
        wr_ctrl(8'h2C); idle(1);
        wr_ctrl(8'h00); idle(1);

        cur_req = "R3"; s_per = 1'b1; tick(); idle(2);
        s_upd = 1'b1; tick(); idle(1);
        cur_req = "R1"; idle(1);

        cur_req = "R4"; wr_ctrl(8'h40); idle(2);
        cur_req = "R2"; wr_ctrl(8'h10); idle(1); wr_ctrl(8'h00); idle(1);
        wr_ctrl(8'h50); idle(1);

        cur_req = "R5"; s_rd = 1'b1; idle(4); s_rd = 1'b0; idle(3);

        cur_req = "R6"; s_rd = 1'b1; s_per = 1'b1; tick(); idle(1);
        s_upd = 1'b1; tick(); idle(1);
        s_rd = 1'b0; s_per = 1'b1; tick(); idle(2);
        s_rd = 1'b1; idle(2); s_rd = 1'b0; s_upd = 1'b1; tick(); idle(2);

        cur_req = "R7"; wr_ctrl(8'h20);
        s_ch = 8'h07; s_cm = 8'h30; s_cs = 8'h15;
        s_ah = 8'h07; s_am = 8'h30; s_as = 8'h15; s_upd = 1'b1; tick(); idle(1);
        s_rd = 1'b1; idle(2); s_rd = 1'b0; idle(1);
        s_as = 8'h16; s_upd = 1'b1; tick(); idle(1);
        s_rd = 1'b1; idle(1); s_rd = 1'b0; idle(1);
        s_as = 8'hC3; s_upd = 1'b1; tick();
        s_ah = 8'hFF; s_am = 8'h31; s_upd = 1'b1; tick();
        s_am = 8'hC0; s_ch = 8'h12; s_upd = 1'b1; tick();
        s_ah = 8'h80; s_upd = 1'b1; tick();
        s_ah = 8'hC0; tick(); idle(1);

        cur_req = "R9"; wr_ctrl(8'h90); idle(1);
        wr_ctrl(8'h10); wr_ctrl(8'hF8); idle(1); wr_ctrl(8'h70); idle(1);

        cur_req = "R8"; s_per = 1'b1; tick(); s_rd = 1'b1; idle(1);
        s_rst_n = 1'b0; idle(2); s_rst_n = 1'b1; s_rd = 1'b0; idle(2);

        cur_req = "R2"; seed = 32'h1234_5678;
        for (int i = 0; i < 2000; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            r = seed;
            s_per = (r[19:17] == 3'd0);
            s_upd = (r[22:20] == 3'd0);
            if (r[25:23] == 3'd0) s_rd = ~s_rd;
            s_we = (r[29:26] == 4'd0);
            s_wdata = r[7:0];
            s_ch = {7'd0, r[8]}; s_cm = {7'd0, r[9]}; s_cs = {7'd0, r[10]};
            s_ah = r[12] ? 8'hC1 : {7'd0, r[11]};
            s_am = r[14] ? 8'hC1 : {7'd0, r[13]};
            s_as = r[16] ? 8'hC1 : {7'd0, r[15]};
            tick();
        end
        s_rd = 1'b0; idle(3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired (all) actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule